// File: doc/BRIEF.md
# Auto-Pointer Processor-to-Bus Bridge

The bridge lets a small 8-bit controller that cannot stretch its own access cycles reach a shared system bus. Every access from the controller side completes in one clock. Bytes to be stored are queued in a write FIFO, and a bus engine drains them as single bus writes. Read traffic is started by a command and runs without the controller. The engine places the returned bytes in a read FIFO, and the controller collects them later.

The bridge holds two address pointers, one for reads and one for writes, and an 8-bit offset register. Every bus cycle targets its pointer plus the offset. The pointer advances by one when the slave acknowledges the cycle. A read command fetches either one byte or a block whose length comes from a length register. A status register lets the controller poll for data, for space in the write FIFO, for outstanding work and for a lost write. On the system side the bridge is a classic Wishbone master with 8-bit data.

Top module: `pbb_bridge`

## Requirements
- R1: After reset both pointers and the offset are 0, the block length is 1, no bus cycle is active and the status register reads 0x02.
- R2: Writing a byte to register 8 queues it. The bridge later writes it on the bus at write pointer plus offset, and the write pointer increases by one when that cycle is acknowledged.
- R3: A bus cycle raises CYC and STB together and keeps them asserted, with stable address, data and direction, until ACK. Both drop in the cycle after ACK.
- R4: Writing register 6 with bit 0 set (bit 1 clear) issues one bus read at read pointer plus offset. The byte goes into the read FIFO and the read pointer increases by one.
- R5: Writing register 6 with bit 1 set issues as many reads at consecutive pointer values as register 5 holds. A length of 0 issues no cycle.
- R6: Reading register 8 returns and removes the oldest byte of the read FIFO. When the FIFO is empty it returns 0x00 and changes nothing.
- R7: Status register 7 gives read-FIFO not-empty in bit 0, write-FIFO not-full in bit 1, busy in bit 2 (a read job pending, a write queued or a cycle in flight) and the overflow flag in bit 3.
- R8: A byte written to register 8 while the write FIFO is full is discarded and sets the overflow flag. The flag stays set until register 7 is written with bit 3 set.
- R9: While the read FIFO is full no new read is issued. The job resumes once a byte is removed, and the bytes keep their bus order.
- R10: A read command that arrives while a read job is still pending is ignored.
- R11: Registers 0/1 hold the read pointer low/high byte and registers 2/3 the write pointer low/high byte. All four can be written and read back. Register 4 is the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Controller register write strobe |
| cpu_re | input | 1 | Controller register read strobe |
| cpu_addr | input | 4 | Register index |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Read data, registered, valid the cycle after cpu_re |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_adr_o | output | ADDR_W | Bus address |
| wb_dat_o | output | 8 | Bus write data |
| wb_dat_i | input | 8 | Bus read data |
| wb_ack_i | input | 1 | Bus acknowledge |

## Verification
The bench goes after four cases. The first is a stalled slave with a full write FIFO. A design that overwrote the FIFO head, or let the fifth byte through, would corrupt memory past the pointer or leave the overflow flag clear. The second is a block longer than the read FIFO. A design that ignored FIFO space would lose bytes or return them out of order. The third covers a zero block length and a command issued during a pending job: an engine that restarted or loaded a count of zero would run extra cycles or wrap to 256 reads. Last, pointer readback after each access catches a pointer that moves on the offset, or before the acknowledge.

// File: rtl/pbb_pkg.sv
package pbb_pkg;
  localparam logic [3:0] REG_RP_LO = 4'h0;
  localparam logic [3:0] REG_RP_HI = 4'h1;
  localparam logic [3:0] REG_WP_LO = 4'h2;
  localparam logic [3:0] REG_WP_HI = 4'h3;
  localparam logic [3:0] REG_OFFS  = 4'h4;
  localparam logic [3:0] REG_BLEN  = 4'h5;
  localparam logic [3:0] REG_CMD   = 4'h6;
  localparam logic [3:0] REG_STAT  = 4'h7;
  localparam logic [3:0] REG_DATA  = 4'h8;

  typedef enum logic {ST_IDLE, ST_BUS} eng_state_t;
endpackage

// File: rtl/pbb_fifo.sv
module pbb_fifo #(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pbb_engine.sv
module pbb_engine
  import pbb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        ptr_ld,
  input  logic [7:0]        ptr_val,
  input  logic [7:0]        offs,
  input  logic [7:0]        blen,
  input  logic              start_single,
  input  logic              start_block,
  input  logic              wf_empty,
  input  logic [7:0]        wf_head,
  output logic              wf_pop,
  input  logic              rf_full,
  output logic              rf_push,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic              busy,
  output logic              wb_cyc,
  output logic              wb_we,
  output logic [ADDR_W-1:0] wb_adr,
  output logic [7:0]        wb_dat,
  input  logic              wb_ack
);
  eng_state_t  state;
  logic [7:0]  remain;
  logic [15:0] rp16, wp16;

  assign rp16    = 16'(rd_ptr);
  assign wp16    = 16'(wr_ptr);
  assign wf_pop  = (state == ST_BUS) && wb_ack && wb_we;
  assign rf_push = (state == ST_BUS) && wb_ack && !wb_we;
  assign busy    = (remain != '0) || wb_cyc || !wf_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      wb_cyc <= 1'b0;
      wb_we  <= 1'b0;
      wb_adr <= '0;
      wb_dat <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
      remain <= '0;
    end else begin
      if (remain == '0) begin
        if (start_block)       remain <= blen;
        else if (start_single) remain <= 8'd1;
      end
      case (state)
        ST_IDLE: begin
          if (!wf_empty) begin
            wb_cyc <= 1'b1;
            wb_we  <= 1'b1;
            wb_adr <= wr_ptr + ADDR_W'(offs);
            wb_dat <= wf_head;
            state  <= ST_BUS;
          end else if (remain != '0 && !rf_full) begin
            wb_cyc <= 1'b1;
            wb_we  <= 1'b0;
            wb_adr <= rd_ptr + ADDR_W'(offs);
            state  <= ST_BUS;
          end
        end
        ST_BUS: begin
          if (wb_ack) begin
            wb_cyc <= 1'b0;
            state  <= ST_IDLE;
            if (wb_we) wr_ptr <= wr_ptr + 1'b1;
            else begin
              rd_ptr <= rd_ptr + 1'b1;
              remain <= remain - 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (ptr_ld[0]) rd_ptr <= ADDR_W'({rp16[15:8], ptr_val});
      if (ptr_ld[1]) rd_ptr <= ADDR_W'({ptr_val, rp16[7:0]});
      if (ptr_ld[2]) wr_ptr <= ADDR_W'({wp16[15:8], ptr_val});
      if (ptr_ld[3]) wr_ptr <= ADDR_W'({ptr_val, wp16[7:0]});
    end
  end
endmodule

// File: rtl/pbb_bridge.sv
module pbb_bridge
  import pbb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int RF_AW  = 2,
  parameter int WF_AW  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_we,
  input  logic              cpu_re,
  input  logic [3:0]        cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic              wb_we_o,
  output logic [ADDR_W-1:0] wb_adr_o,
  output logic [7:0]        wb_dat_o,
  input  logic [7:0]        wb_dat_i,
  input  logic              wb_ack_i
);
  logic [7:0]        offs_q, blen_q;
  logic              ovf_q;
  logic [ADDR_W-1:0] rd_ptr, wr_ptr;
  logic [15:0]       rp16, wp16;
  logic [3:0]        ptr_ld;
  logic              wf_push, wf_pop, wf_full, wf_empty;
  logic              rf_push, rf_pop, rf_full, rf_empty;
  logic [7:0]        wf_head, rf_head;
  logic              busy, start_single, start_block, wr_hit;

  assign wr_hit       = cpu_we;
  assign ptr_ld[0]    = wr_hit && cpu_addr == REG_RP_LO;
  assign ptr_ld[1]    = wr_hit && cpu_addr == REG_RP_HI;
  assign ptr_ld[2]    = wr_hit && cpu_addr == REG_WP_LO;
  assign ptr_ld[3]    = wr_hit && cpu_addr == REG_WP_HI;
  assign start_block  = wr_hit && cpu_addr == REG_CMD && cpu_wdata[1];
  assign start_single = wr_hit && cpu_addr == REG_CMD && cpu_wdata[0];
  assign wf_push      = wr_hit && cpu_addr == REG_DATA;
  assign rf_pop       = cpu_re && cpu_addr == REG_DATA && !rf_empty;
  assign rp16         = 16'(rd_ptr);
  assign wp16         = 16'(wr_ptr);
  assign wb_stb_o     = wb_cyc_o;

  pbb_fifo #(.W(8), .AW(WF_AW)) wfifo_i (
    .clk(clk), .rst(rst), .push(wf_push), .din(cpu_wdata), .pop(wf_pop),
    .dout(wf_head), .full(wf_full), .empty(wf_empty));

  pbb_fifo #(.W(8), .AW(RF_AW)) rfifo_i (
    .clk(clk), .rst(rst), .push(rf_push), .din(wb_dat_i), .pop(rf_pop),
    .dout(rf_head), .full(rf_full), .empty(rf_empty));

  pbb_engine #(.ADDR_W(ADDR_W)) eng_i (
    .clk(clk), .rst(rst), .ptr_ld(ptr_ld), .ptr_val(cpu_wdata),
    .offs(offs_q), .blen(blen_q), .start_single(start_single),
    .start_block(start_block), .wf_empty(wf_empty), .wf_head(wf_head),
    .wf_pop(wf_pop), .rf_full(rf_full), .rf_push(rf_push),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .busy(busy),
    .wb_cyc(wb_cyc_o), .wb_we(wb_we_o), .wb_adr(wb_adr_o),
    .wb_dat(wb_dat_o), .wb_ack(wb_ack_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      offs_q <= '0;
      blen_q <= 8'd1;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_hit && cpu_addr == REG_OFFS) offs_q <= cpu_wdata;
      if (wr_hit && cpu_addr == REG_BLEN) blen_q <= cpu_wdata;
      if (wf_push && wf_full) ovf_q <= 1'b1;
      else if (wr_hit && cpu_addr == REG_STAT && cpu_wdata[3]) ovf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else if (cpu_re) begin
      case (cpu_addr)
        REG_RP_LO: cpu_rdata <= rp16[7:0];
        REG_RP_HI: cpu_rdata <= rp16[15:8];
        REG_WP_LO: cpu_rdata <= wp16[7:0];
        REG_WP_HI: cpu_rdata <= wp16[15:8];
        REG_OFFS:  cpu_rdata <= offs_q;
        REG_BLEN:  cpu_rdata <= blen_q;
        REG_STAT:  cpu_rdata <= {4'b0, ovf_q, busy, !wf_full, !rf_empty};
        REG_DATA:  cpu_rdata <= rf_empty ? 8'h00 : rf_head;
        default:   cpu_rdata <= 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/pbb_bridge_chk.sv
module pbb_bridge_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_we,
  input logic [3:0]        cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              wb_cyc,
  input logic              wb_stb,
  input logic              wb_we,
  input logic [ADDR_W-1:0] wb_adr,
  input logic [7:0]        wb_dat,
  input logic              wb_ack,
  input logic [ADDR_W-1:0] rd_ptr,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic              ovf
);
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && !wb_ack) |=> (wb_cyc && wb_stb && $stable(wb_adr) && $stable(wb_we) && $stable(wb_dat))); // R3
  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && wb_ack) |=> !wb_cyc); // R3
  AST_WR_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && wb_we && wb_ack && !cpu_we) |=> (wr_ptr == ADDR_W'($past(wr_ptr) + 1'b1))); // R2
  AST_RD_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && !wb_we && wb_ack && !cpu_we) |=> (rd_ptr == ADDR_W'($past(rd_ptr) + 1'b1))); // R4
  AST_PTR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!wb_cyc && !cpu_we) |=> ($stable(wr_ptr) && $stable(rd_ptr))); // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !(cpu_we && cpu_addr == 4'h7 && cpu_wdata[3])) |=> ovf); // R8
endmodule

bind pbb_bridge pbb_bridge_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .wb_cyc(wb_cyc_o), .wb_stb(wb_stb_o),
  .wb_we(wb_we_o), .wb_adr(wb_adr_o), .wb_dat(wb_dat_o), .wb_ack(wb_ack_i),
  .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .ovf(ovf_q));

// File: tb/pbb_bridge_tb_top.sv
`timescale 1ns/1ps
module pbb_bridge_tb_top;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cpu_we = 1'b0, cpu_re = 1'b0;
  logic [3:0]        cpu_addr = '0;
  logic [7:0]        cpu_wdata = '0;
  logic [7:0]        cpu_rdata;
  logic              wb_cyc, wb_stb, wb_we;
  logic [ADDR_W-1:0] wb_adr;
  logic [7:0]        wb_dat_o;
  logic [7:0]        wb_dat_i = '0;
  logic              wb_ack = 1'b0;

  logic [7:0]        smem [256];
  logic              stall = 1'b0;
  logic [15:0]       last_wadr = '0;
  logic [7:0]        last_wdat = '0;
  int                rd_cycles = 0;
  int                n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  pbb_bridge #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .wb_cyc_o(wb_cyc), .wb_stb_o(wb_stb), .wb_we_o(wb_we),
    .wb_adr_o(wb_adr), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i),
    .wb_ack_i(wb_ack));

  // bus slave model: acknowledges one half cycle after a strobe appears
  always @(negedge clk) begin
    if (wb_ack) wb_ack = 1'b0;
    else if (wb_cyc && wb_stb && !stall) begin
      wb_ack = 1'b1;
      if (wb_we) begin
        smem[wb_adr[7:0]] = wb_dat_o;
        last_wadr = 16'(wb_adr);
        last_wdat = wb_dat_o;
      end else begin
        wb_dat_i = smem[wb_adr[7:0]];
        rd_cycles++;
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_re = 1'b1; cpu_addr = a;
    @(negedge clk);
    cpu_re = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // {base[15:0], offset[7:0], data[7:0]}
  localparam logic [31:0] WR_VEC [4] = '{
    32'h0010_00_A5, 32'h00F0_05_3C, 32'h12FE_01_77, 32'h0000_FF_81};

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0]  r;
    logic [15:0] base;
    int          c0;
    for (int i = 0; i < 256; i++) smem[i] = 8'h00;
    idle(4);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    cpu_rd(4'h7, r); check("R1 status", 16'(r), 16'h02);
    cpu_rd(4'h5, r); check("R1 blen", 16'(r), 16'h01);
    cpu_rd(4'h1, r); check("R1 rptr hi", 16'(r), 16'h00);
    check("R1 bus idle", 16'(wb_cyc), 16'h0);

    // R2 / R11 write vectors
    foreach (WR_VEC[i]) begin
      base = WR_VEC[i][31:16];
      cpu_wr(4'h2, base[7:0]);
      cpu_wr(4'h3, base[15:8]);
      cpu_wr(4'h4, WR_VEC[i][15:8]);
      cpu_wr(4'h8, WR_VEC[i][7:0]);
      idle(8);
      check("R2 bus address", last_wadr, base + 16'(WR_VEC[i][15:8]));
      check("R2 bus data", 16'(last_wdat), 16'(WR_VEC[i][7:0]));
      cpu_rd(4'h2, r); check("R11 wptr lo", 16'(r), 16'((base + 16'd1) & 16'hFF));
      cpu_rd(4'h3, r); check("R11 wptr hi", 16'(r), 16'((base + 16'd1) >> 8));
    end

    // R4 single read
    smem[8'h23] = 8'h5A;
    cpu_wr(4'h0, 8'h20); cpu_wr(4'h1, 8'h00); cpu_wr(4'h4, 8'h03);
    cpu_wr(4'h6, 8'h01);
    idle(10);
    cpu_rd(4'h7, r); check("R7 status data ready", 16'(r), 16'h03);
    cpu_rd(4'h8, r); check("R4 read data", 16'(r), 16'h5A);
    cpu_rd(4'h0, r); check("R4 rptr advanced", 16'(r), 16'h21);

    // R6 empty read
    cpu_rd(4'h8, r); check("R6 empty read", 16'(r), 16'h00);
    cpu_rd(4'h7, r); check("R6 status unchanged", 16'(r), 16'h02);

    // R5 block of 3
    smem[8'h40] = 8'hC1; smem[8'h41] = 8'hC2; smem[8'h42] = 8'hC3;
    cpu_wr(4'h0, 8'h3E); cpu_wr(4'h4, 8'h02); cpu_wr(4'h5, 8'h03);
    c0 = rd_cycles;
    cpu_wr(4'h6, 8'h02);
    idle(20);
    check("R5 block cycle count", 16'(rd_cycles - c0), 16'd3);
    for (int k = 0; k < 3; k++) begin
      cpu_rd(4'h8, r); check("R5 block data", 16'(r), 16'(8'hC1 + k));
    end
    cpu_rd(4'h0, r); check("R5 rptr after block", 16'(r), 16'h41);

    // R5 zero length
    cpu_wr(4'h5, 8'h00);
    c0 = rd_cycles;
    cpu_wr(4'h6, 8'h02);
    idle(10);
    check("R5 zero length no cycle", 16'(rd_cycles - c0), 16'd0);
    cpu_rd(4'h7, r); check("R5 zero length status", 16'(r), 16'h02);

    // R9 read FIFO full holds the job
    for (int k = 0; k < 6; k++) smem[8'h80 + k] = 8'(k * 7 + 1);
    cpu_wr(4'h0, 8'h80); cpu_wr(4'h4, 8'h00); cpu_wr(4'h5, 8'h06);
    c0 = rd_cycles;
    cpu_wr(4'h6, 8'h02);
    idle(40);
    check("R9 held at fifo depth", 16'(rd_cycles - c0), 16'd4);
    cpu_rd(4'h7, r); check("R9 status full busy", 16'(r), 16'h07);
    for (int k = 0; k < 6; k++) begin
      cpu_rd(4'h8, r); check("R9 order", 16'(r), 16'(k * 7 + 1));
      idle(6);
    end
    cpu_rd(4'h7, r); check("R9 drained", 16'(r), 16'h02);

    // R10 command while job pending
    stall = 1'b1;
    cpu_wr(4'h0, 8'h90); cpu_wr(4'h5, 8'h03);
    c0 = rd_cycles;
    cpu_wr(4'h6, 8'h01);
    idle(3);
    check("R3 cycle waits for ack", 16'(wb_cyc && wb_stb), 16'h1);
    cpu_wr(4'h6, 8'h02);
    stall = 1'b0;
    idle(30);
    check("R10 second command ignored", 16'(rd_cycles - c0), 16'd1);
    cpu_rd(4'h8, r);

    // R8 overflow with stalled slave
    stall = 1'b1;
    cpu_wr(4'h2, 8'h50); cpu_wr(4'h3, 8'h00);
    for (int k = 0; k < 5; k++) cpu_wr(4'h8, 8'(8'h11 + k));
    cpu_rd(4'h7, r); check("R8 status overflow full busy", 16'(r), 16'h0C);
    check("R3 held address", 16'(wb_adr), 16'h0050);
    idle(4);
    check("R3 held data", 16'(wb_dat_o), 16'h11);
    check("R3 still writing", 16'(wb_cyc && wb_we), 16'h1);
    stall = 1'b0;
    idle(40);
    for (int k = 0; k < 4; k++)
      check("R8 kept bytes", 16'(smem[8'h50 + k]), 16'(8'h11 + k));
    check("R8 dropped byte", 16'(smem[8'h54]), 16'h00);
    cpu_rd(4'h7, r); check("R8 sticky", 16'(r), 16'h0A);
    cpu_wr(4'h7, 8'h08);
    cpu_rd(4'h7, r); check("R8 cleared", 16'(r), 16'h02);
    cpu_rd(4'h2, r); check("R8 wptr", 16'(r), 16'h54);

    finish_run();
  end
endmodule